// File: doc/BRIEF.md
# PCI Slot Hotplug Controller

This block keeps the hotplug bookkeeping for the slots of one PCI bus, up to 32 of them. Three per-slot masks are held: occupancy (`present`), removal requests that firmware has not yet acknowledged (`pending`), and slots that may be hot-removed (`hpen`). Slot events arrive as bitmaps, one bit per slot: hot insertion, unplug request and boot-time insertion. A level bitmap marks the slots that hold devices which must never be removed. A hot insertion or an unplug request raises a one-cycle event pulse toward the general-purpose event logic. Firmware then reads the masks through a small 32-bit register window. It acknowledges a removal by writing the slot bit to the eject register, and that makes the block emit a one-hot eject command for the slot.

A platform reset request starts a clean-up sequence. Every removal still pending is completed, one slot per clock cycle, lowest slot first. After that the masks are rebuilt from the occupancy and non-removable bitmaps. The block reports busy for the whole sequence and ignores register accesses until it ends.

Top module: `slot_hotplug_ctrl`

## Requirements
- R1: A 4-byte read at offset 0x0 returns `present` AND `hpen`; read data appears on `rd_data_o` with `rd_valid_o` high one cycle after the access.
- R2: A 4-byte read at offset 0x4 returns the `pending` mask, and a read at offset 0x8 returns zero.
- R3: A 4-byte read at offset 0xC returns the `hpen` mask.
- R4: An access whose `acc_size_i` is not 4 gives no `rd_valid_o` pulse and changes no state: an eject write of size 2 leaves `pending` as it was.
- R5: A 4-byte write to offset 0x8 picks only the lowest set bit of the data as the slot. It clears that slot's `pending` bit and pulses the one-hot `eject_o` for that slot on the following cycle. Write data of zero has no effect.
- R6: An eject clears the slot's `present` bit unless `fixed_i` marks that slot as holding a non-removable device.
- R7: A bit set on `plug_i` sets that slot's `present` bit and gives a one-cycle `gpe_event_o` pulse on the next cycle.
- R8: A bit set on `unplug_i` sets that slot's `pending` bit and gives a one-cycle `gpe_event_o` pulse on the next cycle.
- R9: A bit set on `coldplug_i` sets that slot's `present` bit and gives no `gpe_event_o` pulse.
- R10: A `plat_reset_i` pulse completes every pending removal, one slot per cycle and lowest slot first. Each completion gives an `eject_o` pulse and applies the R6 rule to `present`.
- R11: When the drain ends, `hpen` becomes the complement of `fixed_i` and `present` becomes `occupied_i`. `busy_o` stays high from the reset pulse until this rebuild completes, and register accesses made while busy give no read response and no eject.
- R12: A hardware `rst` clears `pending` without issuing any eject, then rebuilds the masks as in R11 while `busy_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| plat_reset_i | input | 1 | Platform reset request pulse that starts drain and rebuild |
| plug_i | input | NSLOT | Per-slot hot insertion pulse |
| unplug_i | input | NSLOT | Per-slot unplug request pulse |
| coldplug_i | input | NSLOT | Per-slot boot-time insertion pulse |
| fixed_i | input | NSLOT | Slots holding non-removable devices (level) |
| occupied_i | input | NSLOT | Slots currently occupied, used by the rebuild (level) |
| acc_valid_i | input | 1 | Register access strobe |
| acc_write_i | input | 1 | 1 = write, 0 = read |
| acc_off_i | input | 4 | Byte offset inside the register window |
| acc_size_i | input | 3 | Access size in bytes |
| acc_wdata_i | input | 32 | Write data |
| rd_valid_o | output | 1 | Read data valid, one cycle after an accepted read |
| rd_data_o | output | 32 | Read data |
| busy_o | output | 1 | Drain or rebuild in progress |
| gpe_event_o | output | 1 | Hotplug event pulse |
| eject_o | output | NSLOT | One-hot eject command pulse |

## Verification
Hot insertion, boot-time insertion and unplug bitmaps are each applied and then read back. This separates the event-raising paths from the silent one, and separates the `present` mask from the `pending` mask. Eject writes are tried with several bits set, with no bit set, with the wrong size, and on a slot whose device became non-removable after the last rebuild. These cases show lowest-bit selection, that ignored accesses have no effect, and that the non-removable slot keeps its occupancy. The drain is run with two pending slots, one of them non-removable, and a read is issued while the block is busy. The order of the ejects and the rebuilt masks are then compared against the occupancy and non-removable bitmaps.

// File: rtl/slot_hp_pkg.sv
package slot_hp_pkg;

    localparam int          DATA_W    = 32;
    localparam logic [3:0]  OFF_UP    = 4'h0;
    localparam logic [3:0]  OFF_DOWN  = 4'h4;
    localparam logic [3:0]  OFF_EJECT = 4'h8;
    localparam logic [3:0]  OFF_RMV   = 4'hC;
    localparam logic [2:0]  ACC_BYTES = 3'd4;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DRAIN,
        ST_REBUILD
    } trk_state_e;

    typedef struct packed {
        logic [DATA_W-1:0] present;
        logic [DATA_W-1:0] pending;
        logic [DATA_W-1:0] hpen;
    } slot_masks_t;

    // isolate the lowest set bit as a one-hot vector
    function automatic logic [DATA_W-1:0] lowest_onehot(input logic [DATA_W-1:0] v);
        return v & (~v + {{(DATA_W-1){1'b0}}, 1'b1});
    endfunction

endpackage

// File: rtl/hp_reg_port.sv
module hp_reg_port
    import slot_hp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [3:0]        acc_off,
    input  logic [2:0]        acc_size,
    input  logic [DATA_W-1:0] acc_wdata,
    input  logic              busy,
    input  slot_masks_t       masks,
    output logic              ej_req,
    output logic [DATA_W-1:0] ej_data,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);

    logic              acc_ok;
    logic [DATA_W-1:0] rd_mux;

    assign acc_ok  = acc_valid && (acc_size == ACC_BYTES) && !busy;
    assign ej_req  = acc_ok && acc_write && (acc_off == OFF_EJECT);
    assign ej_data = acc_wdata;

    always_comb begin
        unique case (acc_off)
            OFF_UP:   rd_mux = masks.present & masks.hpen;
            OFF_DOWN: rd_mux = masks.pending;
            OFF_RMV:  rd_mux = masks.hpen;
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= acc_ok && !acc_write;
            rd_data  <= (acc_ok && !acc_write) ? rd_mux : '0;
        end
    end

    AST_READ_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(!busy && acc_size == ACC_BYTES)); // R4

endmodule

// File: rtl/hp_slot_tracker.sv
module hp_slot_tracker
    import slot_hp_pkg::*;
#(
    parameter int NSLOT = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              plat_reset,
    input  logic [NSLOT-1:0]  plug,
    input  logic [NSLOT-1:0]  unplug,
    input  logic [NSLOT-1:0]  coldplug,
    input  logic [NSLOT-1:0]  fixed,
    input  logic [NSLOT-1:0]  occupied,
    input  logic              ej_req,
    input  logic [DATA_W-1:0] ej_data,
    output slot_masks_t       masks,
    output logic              busy,
    output logic              gpe_event,
    output logic [NSLOT-1:0]  eject
);

    localparam logic [DATA_W-1:0] SLOT_MASK = (NSLOT >= DATA_W) ? '1 :
                                              ((DATA_W'(1) << NSLOT) - DATA_W'(1));

    logic [DATA_W-1:0] plug_w, unplug_w, cold_w, fixed_w, occ_w;
    always_comb begin
        plug_w   = '0; plug_w[NSLOT-1:0]   = plug;
        unplug_w = '0; unplug_w[NSLOT-1:0] = unplug;
        cold_w   = '0; cold_w[NSLOT-1:0]   = coldplug;
        fixed_w  = '0; fixed_w[NSLOT-1:0]  = fixed;
        occ_w    = '0; occ_w[NSLOT-1:0]    = occupied;
    end

    trk_state_e        st_q, st_n;
    slot_masks_t       m_n;
    logic [DATA_W-1:0] sel, ej_n, ej_q;
    logic              gpe_n, gpe_q;

    always_comb begin
        st_n  = st_q;
        m_n   = masks;
        sel   = '0;
        ej_n  = '0;
        gpe_n = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (plat_reset) begin
                    st_n = ST_DRAIN;
                end else begin
                    if (ej_req) begin
                        sel = lowest_onehot(ej_data & SLOT_MASK);
                    end
                    m_n.pending = m_n.pending & ~sel;
                    if ((sel & fixed_w) == '0) begin
                        m_n.present = m_n.present & ~sel;
                    end
                    ej_n        = sel;
                    m_n.present = m_n.present | plug_w | cold_w;
                    m_n.pending = m_n.pending | unplug_w;
                    gpe_n       = |(plug_w | unplug_w);
                end
            end
            ST_DRAIN: begin
                if (masks.pending == '0) begin
                    st_n = ST_REBUILD;
                end else begin
                    sel         = lowest_onehot(masks.pending);
                    m_n.pending = masks.pending & ~sel;
                    if ((sel & fixed_w) == '0) begin
                        m_n.present = masks.present & ~sel;
                    end
                    ej_n = sel;
                end
            end
            ST_REBUILD: begin
                m_n.hpen    = ~fixed_w & SLOT_MASK;
                m_n.present = occ_w;
                st_n        = ST_IDLE;
            end
            default: st_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_DRAIN;
            masks <= '0;
            ej_q  <= '0;
            gpe_q <= 1'b0;
        end else begin
            st_q  <= st_n;
            masks <= m_n;
            ej_q  <= ej_n;
            gpe_q <= gpe_n;
        end
    end

    assign busy      = (st_q != ST_IDLE);
    assign gpe_event = gpe_q;
    assign eject     = ej_q[NSLOT-1:0];

    AST_EJECT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ej_q)); // R5

    AST_GPE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        gpe_q |-> $past(|(plug_w | unplug_w))); // R9

    AST_DRAIN_STEP: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_DRAIN && masks.pending != '0) |=>
        ($countones(masks.pending) + 1 == $countones($past(masks.pending)))); // R10

    AST_REBUILD_MASK: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_REBUILD) |=> (masks.hpen == (~$past(fixed_w) & SLOT_MASK))); // R11

endmodule

// File: rtl/slot_hotplug_ctrl.sv
module slot_hotplug_ctrl
    import slot_hp_pkg::*;
#(
    parameter int NSLOT = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              plat_reset_i,
    input  logic [NSLOT-1:0]  plug_i,
    input  logic [NSLOT-1:0]  unplug_i,
    input  logic [NSLOT-1:0]  coldplug_i,
    input  logic [NSLOT-1:0]  fixed_i,
    input  logic [NSLOT-1:0]  occupied_i,
    input  logic              acc_valid_i,
    input  logic              acc_write_i,
    input  logic [3:0]        acc_off_i,
    input  logic [2:0]        acc_size_i,
    input  logic [31:0]       acc_wdata_i,
    output logic              rd_valid_o,
    output logic [31:0]       rd_data_o,
    output logic              busy_o,
    output logic              gpe_event_o,
    output logic [NSLOT-1:0]  eject_o
);

    slot_masks_t       masks;
    logic              ej_req;
    logic [DATA_W-1:0] ej_data;

    hp_reg_port u_port (
        .clk       (clk),
        .rst       (rst),
        .acc_valid (acc_valid_i),
        .acc_write (acc_write_i),
        .acc_off   (acc_off_i),
        .acc_size  (acc_size_i),
        .acc_wdata (acc_wdata_i),
        .busy      (busy_o),
        .masks     (masks),
        .ej_req    (ej_req),
        .ej_data   (ej_data),
        .rd_valid  (rd_valid_o),
        .rd_data   (rd_data_o)
    );

    hp_slot_tracker #(.NSLOT(NSLOT)) u_trk (
        .clk        (clk),
        .rst        (rst),
        .plat_reset (plat_reset_i),
        .plug       (plug_i),
        .unplug     (unplug_i),
        .coldplug   (coldplug_i),
        .fixed      (fixed_i),
        .occupied   (occupied_i),
        .ej_req     (ej_req),
        .ej_data    (ej_data),
        .masks      (masks),
        .busy       (busy_o),
        .gpe_event  (gpe_event_o),
        .eject      (eject_o)
    );

endmodule

// File: tb/slot_hotplug_ctrl_tb.sv
module slot_hotplug_ctrl_tb;

    localparam int NSLOT = 32;

    localparam logic [2:0] OP_RD   = 3'd0;
    localparam logic [2:0] OP_WR   = 3'd1;
    localparam logic [2:0] OP_PLUG = 3'd2;
    localparam logic [2:0] OP_UNPL = 3'd3;
    localparam logic [2:0] OP_COLD = 3'd4;
    localparam logic [2:0] OP_RDX  = 3'd5;

    typedef struct packed {
        logic [3:0]  req;
        logic [2:0]  op;
        logic [3:0]  off;
        logic [2:0]  size;
        logic [31:0] data;
        logic [31:0] exp;
    } vec_t;

    localparam int NVEC = 22;
    localparam vec_t VECS [0:NVEC-1] = '{
        '{4'd1,  OP_RD,   4'h0, 3'd4, 32'h0,  32'h0000_0010}, // R1
        '{4'd3,  OP_RD,   4'hC, 3'd4, 32'h0,  32'hFFFF_FFFE}, // R3
        '{4'd2,  OP_RD,   4'h8, 3'd4, 32'h0,  32'h0},         // R2
        '{4'd2,  OP_RD,   4'h4, 3'd4, 32'h0,  32'h0},         // R2
        '{4'd7,  OP_PLUG, 4'h0, 3'd4, 32'h08, 32'h1},         // R7
        '{4'd7,  OP_RD,   4'h0, 3'd4, 32'h0,  32'h18},        // R7
        '{4'd9,  OP_COLD, 4'h0, 3'd4, 32'h20, 32'h0},         // R9
        '{4'd9,  OP_RD,   4'h0, 3'd4, 32'h0,  32'h38},        // R9
        '{4'd8,  OP_UNPL, 4'h0, 3'd4, 32'h18, 32'h1},         // R8
        '{4'd8,  OP_RD,   4'h4, 3'd4, 32'h0,  32'h18},        // R8
        '{4'd5,  OP_WR,   4'h8, 3'd4, 32'h18, 32'h08},        // R5
        '{4'd5,  OP_RD,   4'h4, 3'd4, 32'h0,  32'h10},        // R5
        '{4'd6,  OP_RD,   4'h0, 3'd4, 32'h0,  32'h30},        // R6
        '{4'd4,  OP_WR,   4'h8, 3'd2, 32'h10, 32'h0},         // R4
        '{4'd4,  OP_RD,   4'h4, 3'd4, 32'h0,  32'h10},        // R4
        '{4'd4,  OP_RDX,  4'h0, 3'd1, 32'h0,  32'h0},         // R4
        '{4'd5,  OP_WR,   4'h8, 3'd4, 32'h0,  32'h0},         // R5
        '{4'd5,  OP_WR,   4'h8, 3'd4, 32'h10, 32'h10},        // R5
        '{4'd6,  OP_RD,   4'h0, 3'd4, 32'h0,  32'h20},        // R6
        '{4'd8,  OP_UNPL, 4'h0, 3'd4, 32'h01, 32'h1},         // R8
        '{4'd6,  OP_WR,   4'h8, 3'd4, 32'h01, 32'h01},        // R6
        '{4'd6,  OP_RD,   4'h4, 3'd4, 32'h0,  32'h0}          // R6
    };

    logic              clk = 1'b0;
    logic              rst;
    logic              plat_reset_i;
    logic [NSLOT-1:0]  plug_i, unplug_i, coldplug_i, fixed_i, occupied_i;
    logic              acc_valid_i, acc_write_i;
    logic [3:0]        acc_off_i;
    logic [2:0]        acc_size_i;
    logic [31:0]       acc_wdata_i;
    logic              rd_valid_o;
    logic [31:0]       rd_data_o;
    logic              busy_o;
    logic              gpe_event_o;
    logic [NSLOT-1:0]  eject_o;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done  = 1'b0;

    always #5 clk = ~clk;

    slot_hotplug_ctrl #(.NSLOT(NSLOT)) u_dut (
        .clk(clk), .rst(rst), .plat_reset_i(plat_reset_i),
        .plug_i(plug_i), .unplug_i(unplug_i), .coldplug_i(coldplug_i),
        .fixed_i(fixed_i), .occupied_i(occupied_i),
        .acc_valid_i(acc_valid_i), .acc_write_i(acc_write_i),
        .acc_off_i(acc_off_i), .acc_size_i(acc_size_i), .acc_wdata_i(acc_wdata_i),
        .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o), .busy_o(busy_o),
        .gpe_event_o(gpe_event_o), .eject_o(eject_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        plat_reset_i = 1'b0;
        plug_i = '0; unplug_i = '0; coldplug_i = '0;
        acc_valid_i = 1'b0; acc_write_i = 1'b0;
        acc_off_i = '0; acc_size_i = 3'd4; acc_wdata_i = '0;
    endtask

    task automatic apply(input vec_t v);
        string tag;
        tag = $sformatf("R%0d", v.req);
        @(negedge clk);
        case (v.op)
            OP_PLUG: plug_i     = v.data;
            OP_UNPL: unplug_i   = v.data;
            OP_COLD: coldplug_i = v.data;
            default: begin
                acc_valid_i = 1'b1;
                acc_write_i = (v.op == OP_WR);
                acc_off_i   = v.off;
                acc_size_i  = v.size;
                acc_wdata_i = v.data;
            end
        endcase
        @(negedge clk);
        case (v.op)
            OP_RD: begin
                check(tag, {31'd0, rd_valid_o}, 32'd1);
                check(tag, rd_data_o, v.exp);
            end
            OP_RDX:  check(tag, {31'd0, rd_valid_o}, 32'd0);
            OP_WR:   check(tag, eject_o, v.exp);
            default: check(tag, {31'd0, gpe_event_o}, v.exp);
        endcase
        idle_inputs();
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 10 && busy_o; i++) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [31:0] ej_seen [0:3];
        int          n_ej;
        idle_inputs();
        occupied_i = 32'h11;
        fixed_i    = 32'h01;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R12", {31'd0, busy_o}, 32'd1);          // R12 busy right after reset
        check("R12", {31'd0, rd_valid_o}, 32'd0);
        wait_idle();
        check("R12", {31'd0, busy_o}, 32'd0);

        for (int i = 0; i < NVEC; i++) apply(VECS[i]);

        // R6: slot 6 becomes non-removable after the last rebuild
        apply('{4'd6, OP_COLD, 4'h0, 3'd4, 32'h40, 32'h0});
        fixed_i = 32'h41;
        apply('{4'd6, OP_UNPL, 4'h0, 3'd4, 32'h40, 32'h1});
        apply('{4'd6, OP_WR,   4'h8, 3'd4, 32'h40, 32'h40});
        apply('{4'd6, OP_RD,   4'h0, 3'd4, 32'h0,  32'h60});

        // R10 / R11: drain two pending slots, one non-removable
        fixed_i    = 32'h04;
        occupied_i = 32'h0C;
        apply('{4'd10, OP_UNPL, 4'h0, 3'd4, 32'h24, 32'h1});
        @(negedge clk);
        plat_reset_i = 1'b1;
        @(negedge clk);
        plat_reset_i = 1'b0;
        check("R11", {31'd0, busy_o}, 32'd1);
        acc_valid_i = 1'b1; acc_off_i = 4'h4;     // read while busy
        n_ej = 0;
        for (int c = 0; c < 10 && busy_o; c++) begin
            @(negedge clk);
            if (c == 0) begin
                check("R11", {31'd0, rd_valid_o}, 32'd0);
                acc_write_i = 1'b1; acc_off_i = 4'h8; acc_wdata_i = 32'h08;
            end else begin
                acc_valid_i = 1'b0; acc_write_i = 1'b0;
            end
            if (eject_o != '0 && n_ej < 4) begin
                ej_seen[n_ej] = eject_o;
                n_ej++;
            end
        end
        idle_inputs();
        check("R10", n_ej, 32'd2);
        check("R10", ej_seen[0], 32'h04);
        check("R10", ej_seen[1], 32'h20);
        apply('{4'd11, OP_RD, 4'h0, 3'd4, 32'h0, 32'h08});
        apply('{4'd11, OP_RD, 4'hC, 3'd4, 32'h0, 32'hFFFF_FFFB});
        apply('{4'd10, OP_RD, 4'h4, 3'd4, 32'h0, 32'h0});

        // R12: hardware reset drops pending removals without ejects
        apply('{4'd12, OP_UNPL, 4'h0, 3'd4, 32'h08, 32'h1});
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        n_ej = 0;
        for (int c = 0; c < 10 && (busy_o || c == 0); c++) begin
            @(negedge clk);
            if (eject_o != '0) n_ej++;
        end
        check("R12", n_ej, 32'd0);
        apply('{4'd12, OP_RD, 4'h4, 3'd4, 32'h0, 32'h0});
        apply('{4'd12, OP_RD, 4'h0, 3'd4, 32'h0, 32'h08});

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end

endmodule